// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register

This block keeps the interrupt status of a timekeeping peripheral. Three event sources, periodic tick, alarm match and end of a time update, each set a sticky flag. A flag sets whether or not its enable is on, so software can poll it. The enables come from a control register held elsewhere. While one or more enabled flags are set, an active-low interrupt pin is pulled low.

Software reads the status byte through a select strobe and a read-cycle-active signal. When a read cycle opens, the byte is copied into a capture latch, and the read data comes from that latch for the whole cycle. Once the cycle closes, every flag clears. Events that arrive while a read is open are parked in pending bits and merged into the flags at the clearing edge, so none is lost.

Top module: `rtc_irq_status`

## Requirements
- R1: Status byte layout: bit 7 is the summary flag, bit 6 the periodic flag (event input index 2), bit 5 the alarm flag (index 1) and bit 4 the update-ended flag (index 0).
- R2: A one-cycle pulse on an event input sets its flag at that clock edge whatever the value of its enable bit.
- R3: Bits 3 to 0 of the read data are always 0.
- R4: A read cycle is open while both the select and the read-active inputs are high. The read data loads at the first edge of the cycle and then holds steady until the cycle closes.
- R5: At the second rising edge after the read cycle is sampled closed, all flags that were set clear, and the interrupt pin returns high unless something new is pending.
- R6: An event during an open read leaves the flags and the read data unchanged. It is applied to its flag at the clearing edge.
- R7: An event that arrives exactly at the clearing edge leaves its flag set.
- R8: The interrupt output is low exactly when some source has both its flag and its enable set. It updates at the same edge as the flag and one edge after an enable change.
- R9: The summary bit of a captured byte equals the inverse of the interrupt pin at the capture edge.
- R10: Read-active pulses with the select input low neither capture nor clear anything.
- R11: A synchronous active-high reset clears the flags, the pending bits and the capture latch, and drives the interrupt output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_SRC | Event pulses: [2] periodic, [1] alarm, [0] update-ended |
| en_i | input | NUM_SRC | Interrupt enables from the control register, same order |
| rd_sel_i | input | 1 | Status register is addressed |
| rd_act_i | input | 1 | Read cycle in progress on the bus |
| rd_data_o | output | DATA_W | Captured status byte |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: three sources, an 8-bit byte and the flags at bits 6 to 4. With these settings every combination of flag pattern and enable pattern (64 in all) can be swept. For each one the bench checks the interrupt pin, the captured byte and the clear that follows. Directed sequences then place events inside an open read, on the clearing edge and on unselected read pulses, and assert reset while flags are set.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int STAT_W   = 8;
  localparam int SRC_N    = 3;
  localparam int FLAG_LSB = 4;
endpackage

// File: rtl/rd_cycle_tracker.sv
module rd_cycle_tracker (
  input  logic clk,
  input  logic rst,
  input  logic rd_sel_i,
  input  logic rd_act_i,
  output logic rise_o,
  output logic hold_o,
  output logic clr_o
);
  logic rd_cyc;
  logic rd_q;
  logic clr_q;

  assign rd_cyc = rd_sel_i & rd_act_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      rd_q  <= rd_cyc;
      clr_q <= rd_q & ~rd_cyc;
    end
  end

  assign rise_o = rd_cyc & ~rd_q;
  assign hold_o = rd_cyc | rd_q;
  assign clr_o  = clr_q;
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               hold_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] flags_nxt_o
);
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic f_n;
    logic p_n;

    always_comb begin
      if (clr_i) begin
        f_n = pend_q[i] | (evt_i[i] & ~hold_i);
        p_n = evt_i[i] & hold_i;
      end else if (hold_i) begin
        f_n = flag_q[i];
        p_n = pend_q[i] | evt_i[i];
      end else begin
        f_n = flag_q[i] | evt_i[i];
        p_n = pend_q[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= f_n;
        pend_q[i] <= p_n;
      end
    end

    assign flags_nxt_o[i] = f_n;
  end

  assign flags_o = flag_q;

  // R6
  flags_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !clr_i) |=> $stable(flag_q));

  // R5
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((flag_q & ~$past(pend_q | evt_i)) == '0));
endmodule

// File: rtl/status_capture.sv
module status_capture #(
  parameter int NUM_SRC  = 3,
  parameter int DATA_W   = 8,
  parameter int FLAG_LSB = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rise_i,
  input  logic               hold_i,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] flags_nxt_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_n_o
);
  localparam int SUM_BIT = DATA_W - 1;

  logic [DATA_W-1:0] snap;
  logic [DATA_W-1:0] cap_q;
  logic              irq_n_q;

  always_comb begin
    snap                       = '0;
    snap[FLAG_LSB +: NUM_SRC]  = flags_i;
    snap[SUM_BIT]              = ~irq_n_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= ~|(flags_nxt_i & en_i);
      if (rise_i) cap_q <= snap;
    end
  end

  assign rd_data_o = cap_q;
  assign irq_n_o   = irq_n_q;

  // R4
  capture_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !rise_i) |=> $stable(cap_q));

  // R9
  summary_pin_chk: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> (cap_q[SUM_BIT] == !$past(irq_n_q)));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
  parameter int NUM_SRC  = rtc_irq_pkg::SRC_N,
  parameter int DATA_W   = rtc_irq_pkg::STAT_W,
  parameter int FLAG_LSB = rtc_irq_pkg::FLAG_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               rd_sel_i,
  input  logic               rd_act_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_n_o
);
  logic               rise;
  logic               hold;
  logic               clr;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] flags_nxt;

  rd_cycle_tracker u_trk (
    .clk      (clk),
    .rst      (rst),
    .rd_sel_i (rd_sel_i),
    .rd_act_i (rd_act_i),
    .rise_o   (rise),
    .hold_o   (hold),
    .clr_o    (clr)
  );

  flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .hold_i      (hold),
    .clr_i       (clr),
    .flags_o     (flags),
    .flags_nxt_o (flags_nxt)
  );

  status_capture #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .FLAG_LSB (FLAG_LSB)
  ) u_cap (
    .clk         (clk),
    .rst         (rst),
    .rise_i      (rise),
    .hold_i      (hold),
    .flags_i     (flags),
    .flags_nxt_i (flags_nxt),
    .en_i        (en_i),
    .rd_data_o   (rd_data_o),
    .irq_n_o     (irq_n_o)
  );

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == !(|(flags & $past(en_i))));
endmodule

// File: tb/test_rtc_irq_status.sv
module test_rtc_irq_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] evt = '0;
  logic [2:0] en  = '0;
  logic       rd_sel = 1'b0;
  logic       rd_act = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_irq_status i_rtc_irq_status (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .en_i      (en),
    .rd_sel_i  (rd_sel),
    .rd_act_i  (rd_act),
    .rd_data_o (rd_data),
    .irq_n_o   (irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] m);
    evt = m;
    tick();
    evt = '0;
  endtask

  // Full read: capture, hold with stability checks, close, wait for clear.
  task automatic do_read(input int hold_n, output logic [7:0] got);
    rd_sel = 1'b1;
    rd_act = 1'b1;
    tick();
    got = rd_data;
    for (int k = 0; k < hold_n; k++) begin
      tick();
      chk("R4 stable", rd_data, got);
    end
    rd_act = 1'b0;
    rd_sel = 1'b0;
    tick();
    tick();
  endtask

  function automatic logic [7:0] expect_byte(input logic [2:0] f, input logic [2:0] e);
    return {(|(f & e)), f, 4'b0000};
  endfunction

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 data", rd_data, 8'h00);
    chk("R11 irq", {7'b0, irq_n}, 8'h01);
    rst = 1'b0;
    tick();

    // R1 R2 R3 R8 R9 R5: exhaustive flag x enable sweep
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 8; e++) begin
        logic [2:0] fv;
        logic [2:0] ev;
        fv = f[2:0];
        ev = e[2:0];
        en = ev;
        pulse(fv);
        chk("R8 irq after set", {7'b0, irq_n}, {7'b0, ~|(fv & ev)});
        do_read(2, got);
        chk("R1 R2 R3 R9 byte", got, expect_byte(fv, ev));
        chk("R5 irq after clear", {7'b0, irq_n}, 8'h01);
        do_read(0, got);
        chk("R5 cleared byte", got, 8'h00);
      end
    end

    // R8 enable change after flag set
    en = 3'b000;
    pulse(3'b010);
    chk("R8 disabled", {7'b0, irq_n}, 8'h01);
    en = 3'b010;
    tick();
    chk("R8 enabled later", {7'b0, irq_n}, 8'h00);
    do_read(1, got);
    chk("R8 read", got, 8'hA0);

    // R6 event during open read is deferred
    en = 3'b111;
    rd_sel = 1'b1;
    rd_act = 1'b1;
    tick();
    chk("R6 capture empty", rd_data, 8'h00);
    pulse(3'b010);
    tick();
    chk("R6 data held", rd_data, 8'h00);
    chk("R6 irq held", {7'b0, irq_n}, 8'h01);
    rd_act = 1'b0;
    rd_sel = 1'b0;
    tick();
    chk("R6 before clear", {7'b0, irq_n}, 8'h01);
    tick();
    chk("R6 merged irq", {7'b0, irq_n}, 8'h00);
    do_read(0, got);
    chk("R6 merged byte", got, 8'hA0);

    // R7 event at the clearing edge
    en = 3'b000;
    pulse(3'b100);
    rd_sel = 1'b1;
    rd_act = 1'b1;
    tick();
    chk("R7 capture", rd_data, 8'h40);
    rd_act = 1'b0;
    rd_sel = 1'b0;
    tick();
    pulse(3'b001);
    do_read(0, got);
    chk("R7 survives clear", got, 8'h10);

    // R10 unselected read pulses
    en = 3'b010;
    pulse(3'b010);
    rd_act = 1'b1;
    tick();
    tick();
    rd_act = 1'b0;
    tick();
    tick();
    chk("R10 irq kept", {7'b0, irq_n}, 8'h00);
    chk("R10 no capture", rd_data, 8'h10);
    do_read(0, got);
    chk("R10 flag kept", got, 8'hA0);

    // R11 reset mid-run
    en = 3'b111;
    pulse(3'b111);
    chk("R11 pre", {7'b0, irq_n}, 8'h00);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R11 irq", {7'b0, irq_n}, 8'h01);
    chk("R11 latch", rd_data, 8'h00);
    do_read(0, got);
    chk("R11 flags", got, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule